// File: doc/BRIEF.md
# Sleep Wake-up and Reset-Status Controller

This block decides how a small processor core leaves its halted low-power state, and what the core does next. While the core runs, a halt strobe puts the controller to sleep and raises the power-down flag. A clear-watchdog strobe lowers both status flags. The controller also records which interrupt requests were already raised when the core halted.

While asleep, the controller watches four sources. The first is an external reset request. The second is a watchdog overflow pulse. The third is the interrupt requests, together with their enables and the stack-full indicator. The fourth is the input port, where each pin has its own wake-enable bit. When a source fires, the controller issues exactly one registered one-cycle pulse: a full reset, a partial reset of the program counter and stack pointer, a jump to the interrupt vector, or a resume at the instruction after the halt. A watchdog wake also sets the time-out flag, so software can tell afterwards why the core woke.

Top module: `wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all four pulse outputs and both flags (`to_flag`, `pd_flag`) are 0 and the controller is awake.
- R2: While awake, `halt_op` sets `pd_flag` and enters sleep from the next cycle. `clr_wdt_op` clears `pd_flag` and `to_flag` on the next cycle. If both arrive in the same cycle, `pd_flag` ends at 1.
- R3: `ext_rst_req`, awake or asleep, gives `full_rst` high for one cycle on the next cycle and leaves the controller awake. Neither flag changes.
- R4: `wdt_ovf` while asleep gives `pc_sp_rst` for one cycle on the next cycle, sets `to_flag` and leaves `pd_flag` unchanged. `wdt_ovf` while awake has no effect on any output.
- R5: A high-to-low change on a port pin whose `port_wake_en` bit is 1 wakes a sleeping core. `resume_next` pulses on the third clock edge after the pin change: two edges of synchronizer and one of output register. Falls on disabled pins and rising edges do nothing.
- R6: An interrupt wake in which a waking request has its `irq_en` bit set, with `stack_full` low, gives `take_vector` on the next cycle.
- R7: An interrupt wake in which every waking request is disabled, or `stack_full` is high, gives `resume_next` instead. The request flag is an input and is never cleared by the controller.
- R8: An interrupt request that is high in the cycle `halt_op` is accepted cannot wake the core. It must first drop low while asleep, and only a later rise can wake the core.
- R9: When several wake sources are present in the same sleeping cycle, exactly one pulse is issued. The priority is external reset, then watchdog, then interrupt, then port edge.
- R10: While awake, port edges, interrupt requests and watchdog overflows produce none of `pc_sp_rst`, `resume_next` or `take_vector`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ext_rst_req | input | 1 | External reset request |
| port_in | input | PORT_W | Asynchronous input port pins |
| port_wake_en | input | PORT_W | Per-pin falling-edge wake enable |
| irq_flag | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Interrupt enables |
| stack_full | input | 1 | Return stack has no free level |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| halt_op | input | 1 | Halt instruction strobe |
| clr_wdt_op | input | 1 | Clear-watchdog instruction strobe |
| full_rst | output | 1 | One-cycle full system reset pulse |
| pc_sp_rst | output | 1 | One-cycle program counter and stack pointer reset pulse |
| resume_next | output | 1 | One-cycle pulse: continue after the halt |
| take_vector | output | 1 | One-cycle pulse: take the interrupt vector |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
Two kinds of collision can fall in one sleeping cycle. The first is a watchdog overflow alongside an interrupt request or external reset. The second is an interrupt request alongside a port falling edge, timed so that the edge has just reached the end of the synchronizer. The bench provokes both by raising the sources together, and it pre-ages the port edge by two cycles. A behavioural reference model in the bench predicts the single winning pulse and the flag values on every clock edge, and the bench compares them with the outputs. A priority error or a double pulse then shows as a mismatch.

// File: rtl/wake_ctrl.sv
module wake_ctrl #(
  parameter int PORT_W = 8,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_req,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic [IRQ_N-1:0]  irq_flag,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              stack_full,
  input  logic              wdt_ovf,
  input  logic              halt_op,
  input  logic              clr_wdt_op,
  output logic              full_rst,
  output logic              pc_sp_rst,
  output logic              resume_next,
  output logic              take_vector,
  output logic              to_flag,
  output logic              pd_flag
);

  logic              asleep;
  logic [PORT_W-1:0] pin_s1, pin_s2, pin_old;
  logic [IRQ_N-1:0]  stale;

  wire [PORT_W-1:0] pin_fall  = pin_old & ~pin_s2 & port_wake_en;
  wire [IRQ_N-1:0]  irq_live  = irq_flag & ~stale;
  wire              port_wake = |pin_fall;
  wire              irq_wake  = |irq_live;
  wire              irq_serve = (|(irq_live & irq_en)) & ~stack_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1      <= '0;
      pin_s2      <= '0;
      pin_old     <= '0;
      asleep      <= 1'b0;
      stale       <= '0;
      full_rst    <= 1'b0;
      pc_sp_rst   <= 1'b0;
      resume_next <= 1'b0;
      take_vector <= 1'b0;
      to_flag     <= 1'b0;
      pd_flag     <= 1'b0;
    end else begin
      pin_s1      <= port_in;
      pin_s2      <= pin_s1;
      pin_old     <= pin_s2;
      full_rst    <= 1'b0;
      pc_sp_rst   <= 1'b0;
      resume_next <= 1'b0;
      take_vector <= 1'b0;
      if (ext_rst_req) begin
        full_rst <= 1'b1;
        asleep   <= 1'b0;
      end else if (asleep) begin
        stale <= stale & irq_flag;
        if (wdt_ovf) begin
          pc_sp_rst <= 1'b1;
          to_flag   <= 1'b1;
          asleep    <= 1'b0;
        end else if (irq_wake) begin
          take_vector <= irq_serve;
          resume_next <= ~irq_serve;
          asleep      <= 1'b0;
        end else if (port_wake) begin
          resume_next <= 1'b1;
          asleep      <= 1'b0;
        end
      end else begin
        if (clr_wdt_op) begin
          to_flag <= 1'b0;
          pd_flag <= 1'b0;
        end
        if (halt_op) begin
          pd_flag <= 1'b1;
          asleep  <= 1'b1;
          stale   <= irq_flag;
        end
      end
    end
  end

endmodule

module wake_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic asleep,
  input logic ext_rst_req,
  input logic halt_op,
  input logic stack_full,
  input logic full_rst,
  input logic pc_sp_rst,
  input logic resume_next,
  input logic take_vector,
  input logic to_flag,
  input logic pd_flag
);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full_rst, pc_sp_rst, resume_next, take_vector}));

  a_r3_ext_full: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> full_rst);

  a_r4_wdt_flags: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sp_rst |-> (to_flag && $stable(pd_flag)));

  a_r6_vector_room: assert property (@(posedge clk) disable iff (!rst_n)
    take_vector |-> $past(!stack_full));

  a_r2_halt_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_op && !asleep && !ext_rst_req) |=> (pd_flag && asleep));

  a_r10_awake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !ext_rst_req) |=> !(pc_sp_rst || resume_next || take_vector));

endmodule

bind wake_ctrl wake_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .asleep(asleep), .ext_rst_req(ext_rst_req),
  .halt_op(halt_op), .stack_full(stack_full), .full_rst(full_rst),
  .pc_sp_rst(pc_sp_rst), .resume_next(resume_next), .take_vector(take_vector),
  .to_flag(to_flag), .pd_flag(pd_flag)
);

// File: tb/tb_wake_ctrl.sv
`timescale 1ns/1ps
module tb_wake_ctrl;
  localparam int PW = 8;
  localparam int IN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst_req = 1'b0, stack_full = 1'b0, wdt_ovf = 1'b0;
  logic halt_op = 1'b0, clr_wdt_op = 1'b0;
  logic [PW-1:0] port_in = '0, port_wake_en = '0;
  logic [IN-1:0] irq_flag = '0, irq_en = '0;
  logic full_rst, pc_sp_rst, resume_next, take_vector, to_flag, pd_flag;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  bit m_sleep, m_to, m_pd;
  bit [IN-1:0] m_stale;
  bit [3:0] m_pulse;
  logic [PW-1:0] hist[$];

  always #2 clk = ~clk;

  wake_ctrl #(.PORT_W(PW), .IRQ_N(IN)) dut (
    .clk(clk), .rst_n(rst_n), .ext_rst_req(ext_rst_req), .port_in(port_in),
    .port_wake_en(port_wake_en), .irq_flag(irq_flag), .irq_en(irq_en),
    .stack_full(stack_full), .wdt_ovf(wdt_ovf), .halt_op(halt_op),
    .clr_wdt_op(clr_wdt_op), .full_rst(full_rst), .pc_sp_rst(pc_sp_rst),
    .resume_next(resume_next), .take_vector(take_vector),
    .to_flag(to_flag), .pd_flag(pd_flag));

  task automatic model_reset();
    m_sleep = 0; m_to = 0; m_pd = 0; m_stale = '0; m_pulse = '0;
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_back('0);
  endtask

  // pulse vector order: {full, pcsp, resume, vector}
  task automatic model_step();
    logic [PW-1:0] fell;
    bit [IN-1:0] live;
    bit serve;
    fell = hist[2] & ~hist[1] & port_wake_en;
    hist.push_front(port_in);
    void'(hist.pop_back());
    m_pulse = '0;
    live = irq_flag & ~m_stale;
    serve = ((live & irq_en) != 0) && !stack_full;
    if (ext_rst_req) begin
      m_pulse = 4'b1000; m_sleep = 0;
    end else if (m_sleep) begin
      m_stale = m_stale & irq_flag;
      if (wdt_ovf) begin
        m_pulse = 4'b0100; m_to = 1; m_sleep = 0;
      end else if (live != 0) begin
        m_pulse = serve ? 4'b0001 : 4'b0010; m_sleep = 0;
      end else if (fell != 0) begin
        m_pulse = 4'b0010; m_sleep = 0;
      end
    end else begin
      if (clr_wdt_op) begin m_to = 0; m_pd = 0; end
      if (halt_op) begin m_pd = 1; m_sleep = 1; m_stale = irq_flag; end
    end
  endtask

  task automatic compare();
    logic [5:0] got, exp;
    got = {full_rst, pc_sp_rst, resume_next, take_vector, to_flag, pd_flag};
    exp = {m_pulse, m_to, m_pd};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs got %b exp %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(posedge clk);
      #1;
      compare();
      halt_op = 0; clr_wdt_op = 0; wdt_ovf = 0; ext_rst_req = 0;
    end
  endtask

  task automatic sleep_now();
    halt_op = 1;
    tick(2);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    model_reset();
    repeat (3) @(posedge clk);
    #1;
    tag = "R1"; compare();
    rst_n = 1;
    tick(2);

    tag = "R2"; sleep_now();
    ext_rst_req = 1; tag = "R3"; tick(2);
    clr_wdt_op = 1; tag = "R2"; tick(2);
    halt_op = 1; clr_wdt_op = 1; tick(2);

    tag = "R4"; wdt_ovf = 1; tick(3);
    tag = "R10"; wdt_ovf = 1; tick(2);
    clr_wdt_op = 1; tag = "R2"; tick(1);

    tag = "R5";
    port_in = 8'hFF; port_wake_en = 8'h04; tick(4);
    sleep_now();
    port_in = 8'hFB; tick(4);
    sleep_now();
    port_in = 8'hF3; tick(5);
    port_in = 8'hFF; tick(5);
    ext_rst_req = 1; tag = "R3"; tick(2);

    tag = "R10";
    port_in = 8'hFB; irq_flag = 4'h1; irq_en = 4'h1; tick(4);
    irq_flag = 0; port_in = 8'hFF; tick(4);

    tag = "R6"; sleep_now();
    irq_flag = 4'h2; irq_en = 4'h2; tick(2); irq_flag = 0; tick(1);
    tag = "R7"; sleep_now();
    irq_flag = 4'h2; irq_en = 4'h0; tick(2); irq_flag = 0; tick(1);
    sleep_now();
    irq_flag = 4'h8; irq_en = 4'hF; stack_full = 1; tick(2);
    irq_flag = 0; stack_full = 0; tick(1);

    tag = "R8";
    irq_flag = 4'h4; irq_en = 4'hF; sleep_now();
    tick(4);
    irq_flag = 4'h0; tick(2);
    irq_flag = 4'h4; tick(2); irq_flag = 0; tick(1);

    tag = "R9";
    sleep_now();
    wdt_ovf = 1; irq_flag = 4'h1; tick(2); irq_flag = 0; tick(1);
    sleep_now();
    wdt_ovf = 1; ext_rst_req = 1; tick(2);
    sleep_now();
    port_in = 8'hFB; tick(2);
    irq_flag = 4'h1; irq_en = 4'h0; tick(3);
    irq_flag = 0; port_in = 8'hFF; tick(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule